// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block detects read-after-write hazards for a five-stage in-order integer pipeline that has no forwarding paths. Each cycle it looks at the fields of the instruction sitting in decode: major opcode, two source register indices and the destination index. From the opcode it works out whether each source is actually read and whether the destination is actually written.

It keeps a short shift record of the destination index and write flag for the instructions now in execute, memory and writeback. When a source that decode really reads names a register that one of those three downstream instructions will write, the block raises a stall. The stall freezes the program counter and the fetch/decode register. In the same cycle a bubble request tells the execute stage to take a no-op in place of the held instruction.

The register file gives no same-cycle write-then-read. A consumer issued directly behind its producer therefore waits three cycles in decode and enters execute one cycle after the producer's writeback cycle.

Top module: `ilk_stall_ctrl`

## Requirements
- R1: The destination is treated as written for opcodes 0110011 (register ALU), 0010011 (immediate ALU), 0000011 (load), 1101111 (jump-and-link) and 1100111 (register jump-and-link). It is not written for 0100011 (store) or 1100011 (conditional branch).
- R2: The first source (rs1) is treated as read for every recognised opcode except 1101111. A match on rs1 of a 1101111 instruction never stalls.
- R3: The second source (rs2) is treated as read only for 0110011, 0100011 and 1100011. A match on rs2 for any other opcode never stalls.
- R4: stall_o is high in a cycle exactly when a read source index equals the destination of a writing instruction in execute, memory or writeback.
- R5: A destination index of 0 never produces a match.
- R6: bubble_o equals stall_o in every cycle. A stalled cycle sends a non-writing slot into execute, and the held instruction enters execute only in the first non-stalled cycle.
- R7: A dependent instruction placed directly behind its producer sees stall_o high for exactly three cycles and low on the fourth. A run of stall cycles never exceeds three.
- R8: Any opcode other than the seven listed in R1 reads nothing and writes nothing.
- R9: Asserting rst_ni clears all three tracked slots at once, so stall_o is low during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 7 | Major opcode of the decode-stage instruction |
| rs1_i | input | 5 | First source register index in decode |
| rs2_i | input | 5 | Second source register index in decode |
| rd_i | input | 5 | Destination register index in decode |
| stall_o | output | 1 | Hold the program counter and the decode register |
| bubble_o | output | 1 | Load a non-writing no-op into execute |

## Verification
The bench places consumers at one, two and three slots from their producers. A design that skipped the writeback compare would release after two cycles, and one that let a bubble carry its held destination would stall forever.

Stores and branches placed ahead of readers of their rd field show whether the write gating works. A jump-and-link with a matching rs1 field, an immediate ALU with a matching rs2 field, and an unrecognised opcode show whether read gating is done per opcode. A design without that gating stalls where no hazard exists.

Writes to register 0, and reads of register 0, check that the zero register is excluded. A reset asserted in the middle of a stall must drop the stall at once.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int unsigned REG_W = 5;
  parameter int unsigned OP_W  = 7;
  parameter int unsigned DEPTH = 3;  // execute, memory, writeback

  typedef struct packed {
    logic             we;
    logic [REG_W-1:0] ws;
  } dst_t;

  localparam logic [OP_W-1:0] OP_ALU  = 7'b0110011;
  localparam logic [OP_W-1:0] OP_ALUI = 7'b0010011;
  localparam logic [OP_W-1:0] OP_LD   = 7'b0000011;
  localparam logic [OP_W-1:0] OP_ST   = 7'b0100011;
  localparam logic [OP_W-1:0] OP_BR   = 7'b1100011;
  localparam logic [OP_W-1:0] OP_JAL  = 7'b1101111;
  localparam logic [OP_W-1:0] OP_JALR = 7'b1100111;
endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
  import ilk_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output logic            re1_o,
  output logic            re2_o,
  output logic            we_o
);
  always_comb begin
    re1_o = 1'b0;
    re2_o = 1'b0;
    we_o  = 1'b0;
    unique case (opcode_i)
      OP_ALU:  begin re1_o = 1'b1; re2_o = 1'b1; we_o = 1'b1; end
      OP_ALUI: begin re1_o = 1'b1; we_o = 1'b1; end
      OP_LD:   begin re1_o = 1'b1; we_o = 1'b1; end
      OP_ST:   begin re1_o = 1'b1; re2_o = 1'b1; end
      OP_BR:   begin re1_o = 1'b1; re2_o = 1'b1; end
      OP_JALR: begin re1_o = 1'b1; we_o = 1'b1; end
      OP_JAL:  begin we_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ilk_track.sv
module ilk_track
  import ilk_pkg::*;
#(
  parameter int unsigned N = DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dst_t             push_i,
  output dst_t [N-1:0]     slot_o
);
  dst_t [N-1:0] q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= '0;
        else         q[g] <= (g == 0) ? push_i : q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign slot_o = q;
endmodule

// File: rtl/ilk_match.sv
module ilk_match
  import ilk_pkg::*;
#(
  parameter int unsigned N = DEPTH
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             re_i,
  input  dst_t [N-1:0]     slot_i,
  output logic             hit_o
);
  logic [N-1:0] hit;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      // x0 is hardwired, never a real dependency
      assign hit[g] = slot_i[g].we && (slot_i[g].ws != '0) && (slot_i[g].ws == src_i);
    end
  endgenerate

  assign hit_o = re_i && (|hit);
endmodule

// File: rtl/ilk_stall_ctrl.sv
module ilk_stall_ctrl
  import ilk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [REG_W-1:0] rd_i,
  output logic             stall_o,
  output logic             bubble_o
);
  logic re1, re2, we;
  logic hit1, hit2, stall;
  dst_t push;
  dst_t [DEPTH-1:0] slot;

  ilk_decode u_dec (
    .opcode_i (opcode_i),
    .re1_o    (re1),
    .re2_o    (re2),
    .we_o     (we)
  );

  // stalled cycle injects an empty slot
  always_comb begin
    push = '0;
    if (!stall) begin
      push.we = we;
      push.ws = rd_i;
    end
  end

  ilk_track #(.N(DEPTH)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .slot_o (slot)
  );

  ilk_match #(.N(DEPTH)) u_m1 (
    .src_i  (rs1_i),
    .re_i   (re1),
    .slot_i (slot),
    .hit_o  (hit1)
  );

  ilk_match #(.N(DEPTH)) u_m2 (
    .src_i  (rs2_i),
    .re_i   (re2),
    .slot_i (slot),
    .hit_o  (hit2)
  );

  assign stall    = hit1 | hit2;
  assign stall_o  = stall;
  assign bubble_o = stall;
endmodule

// File: rtl/ilk_stall_ctrl_chk.sv
module ilk_stall_ctrl_chk
  import ilk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  opcode_i,
  input logic [REG_W-1:0] rs1_i,
  input logic [REG_W-1:0] rs2_i,
  input logic             stall_o,
  input logic             bubble_o
);
  localparam int unsigned CW = $clog2(DEPTH + 2);
  logic [CW-1:0] run_q;
  logic          seen_q;
  logic          known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (stall_o && run_q <= CW'(DEPTH)) run_q <= run_q + 1'b1;
      else if (!stall_o)                  run_q <= '0;
    end
  end

  assign known = (opcode_i == OP_ALU) || (opcode_i == OP_ALUI) || (opcode_i == OP_LD) ||
                 (opcode_i == OP_ST) || (opcode_i == OP_BR) || (opcode_i == OP_JAL) ||
                 (opcode_i == OP_JALR);

  AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_i == '0 && rs2_i == '0) |-> !stall_o); // R5
  AST_JAL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_JAL) |-> !stall_o); // R2
  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !stall_o); // R8
  AST_STALL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= CW'(DEPTH)) |-> !stall_o); // R7
  AST_RESET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !stall_o); // R9
  AST_BUBBLE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o == stall_o); // R6
endmodule

bind ilk_stall_ctrl ilk_stall_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opcode_i (opcode_i),
  .rs1_i    (rs1_i),
  .rs2_i    (rs2_i),
  .stall_o  (stall_o),
  .bubble_o (bubble_o)
);

// File: tb/ilk_stall_ctrl_test.sv
module ilk_stall_ctrl_test;
  import ilk_pkg::*;

  localparam int NV = 34;
  localparam logic [6:0] OP_OTH = 7'b0110111;

  // {opcode, rs1, rs2, rd, expected stall}, one row per cycle
  localparam logic [22:0] VEC [NV] = '{
    {OP_ALU,  5'd2,  5'd3,  5'd1,  1'b0}, // 1  R9 empty after reset
    {OP_ALUI, 5'd1,  5'd0,  5'd4,  1'b1}, // 2  R4 R7 hit in execute
    {OP_ALUI, 5'd1,  5'd0,  5'd4,  1'b1}, // 3  R7 hit in memory
    {OP_ALUI, 5'd1,  5'd0,  5'd4,  1'b1}, // 4  R7 hit in writeback
    {OP_ALUI, 5'd1,  5'd0,  5'd4,  1'b0}, // 5  R7 released on fourth
    {OP_ST,   5'd5,  5'd4,  5'd4,  1'b1}, // 6  R3 store reads rs2
    {OP_ST,   5'd5,  5'd4,  5'd4,  1'b1}, // 7
    {OP_ST,   5'd5,  5'd4,  5'd4,  1'b1}, // 8
    {OP_ST,   5'd5,  5'd4,  5'd4,  1'b0}, // 9  R6 bubbles carried no write
    {OP_ALUI, 5'd4,  5'd0,  5'd7,  1'b0}, // 10 R1 store does not write
    {OP_JAL,  5'd7,  5'd7,  5'd1,  1'b0}, // 11 R2 jal reads nothing
    {OP_OTH,  5'd1,  5'd1,  5'd6,  1'b0}, // 12 R8 unknown reads nothing
    {OP_ALU,  5'd6,  5'd9,  5'd0,  1'b0}, // 13 R8 unknown writes nothing
    {OP_ALU,  5'd1,  5'd9,  5'd0,  1'b1}, // 14 R1 jal writes, hit in wb
    {OP_ALU,  5'd1,  5'd9,  5'd0,  1'b0}, // 15
    {OP_ALU,  5'd0,  5'd0,  5'd3,  1'b0}, // 16 R5 x0 write never matches
    {OP_BR,   5'd3,  5'd8,  5'd9,  1'b1}, // 17 R2 branch reads rs1
    {OP_BR,   5'd3,  5'd8,  5'd9,  1'b1}, // 18
    {OP_BR,   5'd3,  5'd8,  5'd9,  1'b1}, // 19
    {OP_BR,   5'd3,  5'd8,  5'd9,  1'b0}, // 20
    {OP_JALR, 5'd9,  5'd3,  5'd5,  1'b0}, // 21 R1 branch does not write
    {OP_LD,   5'd5,  5'd0,  5'd10, 1'b1}, // 22 R1 jalr writes
    {OP_LD,   5'd5,  5'd0,  5'd10, 1'b1}, // 23
    {OP_LD,   5'd5,  5'd0,  5'd10, 1'b1}, // 24
    {OP_LD,   5'd5,  5'd0,  5'd10, 1'b0}, // 25
    {OP_ALU,  5'd11, 5'd10, 5'd13, 1'b1}, // 26 R3 alu reads rs2, R1 load writes
    {OP_ALU,  5'd11, 5'd10, 5'd13, 1'b1}, // 27
    {OP_ALU,  5'd11, 5'd10, 5'd13, 1'b1}, // 28
    {OP_ALU,  5'd11, 5'd10, 5'd13, 1'b0}, // 29
    {OP_ALUI, 5'd0,  5'd13, 5'd12, 1'b0}, // 30 R3 immediate ignores rs2
    {OP_LD,   5'd12, 5'd0,  5'd14, 1'b1}, // 31 R4 load reads rs1
    {OP_LD,   5'd12, 5'd0,  5'd14, 1'b1}, // 32
    {OP_LD,   5'd12, 5'd0,  5'd14, 1'b1}, // 33
    {OP_LD,   5'd12, 5'd0,  5'd14, 1'b0}  // 34
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [6:0] opcode_i = '0;
  logic [4:0] rs1_i = '0, rs2_i = '0, rd_i = '0;
  logic stall_o, bubble_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ilk_stall_ctrl uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .rd_i     (rd_i),
    .stall_o  (stall_o),
    .bubble_o (bubble_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state with a would-be hazard on the inputs
    opcode_i = OP_ALU; rs1_i = 5'd1; rs2_i = 5'd1; rd_i = 5'd1;
    repeat (2) @(negedge clk_i);
    check("R9 stall in reset", stall_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {opcode_i, rs1_i, rs2_i, rd_i} = VEC[i][22:1];
      #2;
      check($sformatf("R4 row %0d stall", i + 1), stall_o, VEC[i][0]);
      check($sformatf("R6 row %0d bubble", i + 1), bubble_o, VEC[i][0]);
    end

    // R4 consumer of the load now in execute, then R9 reset mid-stall
    @(negedge clk_i);
    opcode_i = OP_ALUI; rs1_i = 5'd14; rs2_i = 5'd0; rd_i = 5'd15;
    #2;
    check("R4 load hazard", stall_o, 1'b1);
    rst_ni = 1'b0;
    #2;
    check("R9 async clear", stall_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    check("R9 first cycle after reset", stall_o, 1'b0);
    check("R6 bubble after reset", bubble_o, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule